// File: doc/BRIEF.md
# Grouped bus-invert link encoder

This block sits at the transmit end of a wide parallel link and recodes each data word to cut the number of wires that toggle between transfers. A two-bit mode input picks the coding for each transfer. In pass mode the word goes out unchanged. In XOR mode the link carries the difference between the word and the previous word. In invert mode the word is cut into equal groups, and each group has its own flag wire. A group is sent complemented, with its flag set, whenever that gives fewer toggles against what the same wires carried last.

The encoded bus is registered. It appears one clock after a valid input, together with an output strobe, and it holds its value between transfers. A saturating tally adds up the wires that changed on each transfer. Only the wires that the chosen mode uses are counted, so power estimates can be read straight from the block.

Top module: `linkenc_top`

## Requirements
- R1: Mode code 0 or 3 (pass) drives the data word on out_bus[DATA_W-1:0] and drives every bit above DATA_W-1 to 0.
- R2: Mode code 1 (XOR) drives the XOR of the data word with the data word of the previous valid transfer, whatever mode that transfer used, on the low DATA_W bits, with the upper bits at 0. After reset, the previous word is 0.
- R3: Mode code 2 (invert) places group k in bus bits k*(G+1) up to k*(G+1)+G. The group's data bits sit in the low G positions and its flag sits at position k*(G+1)+G. G is the effective group width and the bus is DATA_W + DATA_W/G bits wide.
- R4: In invert mode a group is complemented and its flag set to 1 when the Hamming distance is strictly greater than G/2 (integer division). The distance is taken between the G+1 bus bits the group drove last (including the old flag) and the new data group with a 0 in the flag position. Otherwise the group is sent unchanged with the flag at 0.
- R5: Each group decides from its own data and its own previous bus slice only.
- R6: A group width parameter of 0, or one larger than DATA_W, makes the whole word one group.
- R7: On each valid transfer the tally grows by the number of bus bits that changed between the previous and the new bus value. In pass and XOR modes only the low DATA_W bits are counted; in invert mode all bus bits are counted.
- R8: The tally (CNT_W bits, default 32) stops at its maximum value instead of wrapping.
- R9: Reset sets the bus register, the previous data word, the tally and out_valid to 0.
- R10: The outputs follow a valid input by one clock, with out_valid high for that cycle only. When in_valid is low, out_bus, the tally and the stored previous word do not change. A change of mode takes effect on the next valid transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies in_data and in_mode for a transfer |
| in_mode | input | 2 | 0/3 pass, 1 XOR, 2 invert |
| in_data | input | DATA_W | Data word to send |
| out_valid | output | 1 | High one cycle after each transfer |
| out_bus | output | DATA_W + DATA_W/G | Registered encoded bus |
| toggle_cnt | output | CNT_W | Saturating count of bus bit changes |

## Verification
The hardest case to reach is a group whose decision turns on its old flag bit. There the distance over the data bits alone is at or below half the group width, and the flagged old slice tips it over the threshold. The stimulus first forces a group into the inverted state, then sends a word that differs from the old wire values in few data bits. This exposes any comparison that leaves out the flag. Saturation cannot be reached through traffic at 32 bits, so the bench builds the block with a narrow tally and feeds it all-ones and all-zeros words in turn. A second instance with group width 0 covers the single-group fallback.

// File: rtl/linkenc_pkg.sv
package linkenc_pkg;

  typedef enum logic [1:0] {
    MODE_PASS     = 2'd0,
    MODE_XOR      = 2'd1,
    MODE_INV      = 2'd2,
    MODE_PASS_ALT = 2'd3
  } link_mode_e;

  // Group width actually used: out-of-range settings collapse to one group.
  function automatic int eff_group(input int dw, input int gw);
    return (gw == 0 || gw > dw) ? dw : gw;
  endfunction

endpackage

// File: rtl/linkenc_group.sv
module linkenc_group #(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic [GW:0]   prev_slot,
  input  logic [GW-1:0] data_grp,
  output logic [GW:0]   slot_out
);

  localparam int HALF  = GW / 2;
  localparam int LIMIT = (GW + 1) / 2;

  function automatic logic want_flip(input logic [GW:0] old_s,
                                     input logic [GW-1:0] nd);
    return $countones(old_s ^ {1'b0, nd}) > HALF;
  endfunction

  logic flip;

  always_comb begin
    flip     = want_flip(prev_slot, data_grp);
    slot_out = flip ? {1'b1, ~data_grp} : {1'b0, data_grp};
  end

  // R4
  grp_toggle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> ($countones(slot_out ^ prev_slot) <= LIMIT));

endmodule

// File: rtl/linkenc_tally.sv
module linkenc_tally #(
  parameter int CW = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_en,
  input  logic [IW-1:0] add_val,
  output logic [CW-1:0] total
);

  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a,
                                            input logic [IW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {{(CW + 1 - IW){1'b0}}, b};
    return s[CW] ? TOP : s[CW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      total <= '0;
    else if (add_en) total <= sat_add(total, add_val);
  end

  // R8
  tally_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (total >= $past(total)));

  // R8
  tally_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (total == TOP) |=> (total == TOP));

  // R10
  tally_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en |=> $stable(total));

endmodule

// File: rtl/linkenc_top.sv
module linkenc_top
  import linkenc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GRP_W  = 4,
  parameter int CNT_W  = 32,
  localparam int GW    = eff_group(DATA_W, GRP_W),
  localparam int NGRP  = DATA_W / GW,
  localparam int BUS_W = DATA_W + NGRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_mode,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [BUS_W-1:0]  out_bus,
  output logic [CNT_W-1:0]  toggle_cnt
);

  localparam int SLOT  = GW + 1;
  localparam int POP_W = $clog2(BUS_W + 1);

  logic [BUS_W-1:0]  bus_q, bus_d, inv_bus, cnt_mask;
  logic [DATA_W-1:0] data_q;
  logic              vld_q;
  logic              mode_inv, mode_xor;
  logic [POP_W-1:0]  hop;

  assign mode_inv = (link_mode_e'(in_mode) == MODE_INV);
  assign mode_xor = (link_mode_e'(in_mode) == MODE_XOR);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    linkenc_group #(.GW(GW)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .chk_en    (in_valid && mode_inv),
      .prev_slot (bus_q[g*SLOT +: SLOT]),
      .data_grp  (in_data[g*GW +: GW]),
      .slot_out  (inv_bus[g*SLOT +: SLOT])
    );
  end

  always_comb begin
    if (mode_inv) begin
      bus_d    = inv_bus;
      cnt_mask = {BUS_W{1'b1}};
    end else begin
      bus_d    = mode_xor ? {{NGRP{1'b0}}, in_data ^ data_q}
                          : {{NGRP{1'b0}}, in_data};
      cnt_mask = {{NGRP{1'b0}}, {DATA_W{1'b1}}};
    end
    hop = POP_W'($countones((bus_d ^ bus_q) & cnt_mask));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        bus_q  <= bus_d;
        data_q <= in_data;
      end
    end
  end

  linkenc_tally #(.CW(CNT_W), .IW(POP_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (in_valid),
    .add_val (hop),
    .total   (toggle_cnt)
  );

  assign out_bus   = bus_q;
  assign out_valid = vld_q;

  // R1
  pass_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_inv && !mode_xor) |=> (out_bus[DATA_W-1:0] == $past(in_data)));

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_inv) |=> (out_bus[BUS_W-1:DATA_W] == '0));

  // R2
  xor_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_xor) |=> ((out_bus[DATA_W-1:0] ^ $past(out_bus[DATA_W-1:0])) ==
                                ($past(in_data ^ data_q) ^ $past(out_bus[DATA_W-1:0]))));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_bus) && !out_valid));

endmodule

// File: tb/linkenc_top_tb.sv
`timescale 1ns/1ps
module linkenc_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_mode = 2'd0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid, one_valid;
  logic [9:0] out_bus;
  logic [8:0] one_bus;
  logic [5:0] toggle_cnt, one_cnt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  linkenc_top #(.DATA_W(8), .GRP_W(4), .CNT_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_data(in_data), .out_valid(out_valid), .out_bus(out_bus),
    .toggle_cnt(toggle_cnt));

  // R6: group width 0 falls back to one 8-bit group, 9-bit bus
  linkenc_top #(.DATA_W(8), .GRP_W(0), .CNT_W(6)) u_dut_one (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_data(in_data), .out_valid(one_valid), .out_bus(one_bus),
    .toggle_cnt(one_cnt));

  // {mode, data, expected bus, expected tally}, applied in order after reset
  localparam logic [25:0] VEC [10] = '{
    {2'd2, 8'hFF, 10'h210, 6'd2},
    {2'd2, 8'hF0, 10'h200, 6'd3},
    {2'd2, 8'h3C, 10'h38C, 6'd7},
    {2'd1, 8'h5A, 10'h066, 6'd12},
    {2'd0, 8'hA5, 10'h0A5, 6'd16},
    {2'd3, 8'h0F, 10'h00F, 6'd20},
    {2'd1, 8'h0F, 10'h000, 6'd24},
    {2'd2, 8'h00, 10'h000, 6'd24},
    {2'd2, 8'h07, 10'h018, 6'd26},
    {2'd2, 8'h0E, 10'h011, 6'd28}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [1:0] m, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_mode  = m;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R9 bus after reset", 32'(out_bus), 32'h0);
    chk("R9 tally after reset", 32'(toggle_cnt), 32'h0);
    chk("R9 valid after reset", 32'(out_valid), 32'h0);

    for (int i = 0; i < 10; i++) begin
      logic [25:0] v;
      v = VEC[i];
      xfer(v[25:24], v[23:16]);
      chk("R10 out_valid one cycle after input", 32'(out_valid), 32'h1);
      if (v[25:24] == 2'd2)
        chk($sformatf("R3 R4 R5 invert vec %0d", i), 32'(out_bus), 32'(v[15:6]));
      else if (v[25:24] == 2'd1)
        chk($sformatf("R2 xor vec %0d", i), 32'(out_bus), 32'(v[15:6]));
      else
        chk($sformatf("R1 pass vec %0d", i), 32'(out_bus), 32'(v[15:6]));
      chk($sformatf("R7 tally vec %0d", i), 32'(toggle_cnt), 32'(v[5:0]));
    end

    // R10: idle cycle, data changes without valid, nothing moves
    @(negedge clk);
    in_data = 8'hFF;
    in_mode = 2'd0;
    @(negedge clk);
    chk("R10 valid low when idle", 32'(out_valid), 32'h0);
    chk("R10 bus held when idle", 32'(out_bus), 32'h011);
    chk("R10 tally held when idle", 32'(toggle_cnt), 32'd28);

    // R9: reset mid-run clears everything
    do_reset();
    chk("R9 bus after mid reset", 32'(out_bus), 32'h0);
    chk("R9 tally after mid reset", 32'(toggle_cnt), 32'h0);

    // R6: single group decisions
    xfer(2'd2, 8'h1F);
    chk("R6 single group first", 32'(one_bus), 32'h1E0);
    xfer(2'd2, 8'h0F);
    chk("R6 single group second", 32'(one_bus), 32'h1F0);

    // R8: 8 toggles per transfer, 6-bit tally saturates at 63
    do_reset();
    for (int i = 0; i < 7; i++) xfer(2'd0, (i % 2 == 0) ? 8'hFF : 8'h00);
    chk("R7 tally before saturation", 32'(toggle_cnt), 32'd56);
    xfer(2'd0, 8'h00);
    chk("R8 tally clamps", 32'(toggle_cnt), 32'd63);
    xfer(2'd0, 8'hFF);
    chk("R8 tally stays at max", 32'(toggle_cnt), 32'd63);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule